// File: doc/BRIEF.md
# Two-Channel Capture/Compare Timer

This block is a 16-bit timer with two capture/compare channels. Software reaches it through a small word-addressed register port. The counter has four counting modes and a power-of-two input prescaler, and it raises an overflow flag on each wrap. Each channel works in one of two ways. It can latch the counter value on chosen edges of a selectable input, or it can compare the counter against its value register and shape an output pin through one of eight waveform rules.

Channel 0 has its own interrupt line. Channel 1 and the counter overflow share a second line. A vector register reports which of those two sources is pending, in priority order, and reading it acknowledges the source it reported. Timing comes from one clock plus a count-enable input. A capture input can optionally pass through a two-stage synchroniser before its edges are detected.

The register port carries no data stream, so it is a plain strobe interface. `bus_rdata` is combinational from `bus_addr` and is valid in the same cycle. A write or a read strobe takes effect on the rising clock edge. There is no back-pressure: the port accepts every access in one cycle.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter, every register, both outputs and both interrupt lines are 0, and the vector register reads 0.
- R2: Control register (address 0): bit 0 overflow flag, bit 1 overflow interrupt enable, bit 2 clear, bits 5:4 counting mode, bits 7:6 prescaler code. Mode 0 holds the counter. In mode 1 the counter climbs to the channel-0 value (address 4), and on the next tick it returns to 0 and sets the overflow flag.
- R3: In mode 2 the counter runs through 0xFFFF to 0, and the overflow flag sets on that wrap. Writing address 1 loads the counter.
- R4: In mode 3 the counter climbs to the channel-0 value, then descends to 0 and turns upward again. The overflow flag sets on the tick where the descending count reaches 0.
- R5: Prescaler codes 0, 1, 2 and 3 give one counter tick every 1, 2, 4 or 8 enabled clocks.
- R6: Writing 1 to the clear bit zeroes the counter and the prescaler in that cycle. The clear bit always reads back 0.
- R7: Channel control (address 2 for channel 0, address 3 for channel 1) has these fields: bit 0 flag, bit 1 capture overflow, bit 2 output level, bit 3 interrupt enable, bit 4 capture mode, bits 7:5 output mode, bits 9:8 edge select (0 none, 1 rising, 2 falling, 3 both), bits 11:10 input select (0 input A, 1 input B, 2 constant 0, 3 constant 1), bit 12 synchronise. In capture mode a selected edge copies the counter into the channel value register (addresses 4 and 5) and sets the flag. Edges that are not selected change nothing.
- R8: A capture while the channel flag is already set also sets the capture-overflow bit.
- R9: With the synchronise bit set, a capture lands two clocks later than without it.
- R10: Output modes: 0 drives the output from bit 2; 1 set; 2 toggle/reset; 3 set/reset; 4 toggle; 5 reset; 6 toggle/set; 7 reset/set. The first action happens on the tick where the counter reaches the channel's own value. The second happens on the tick where it reaches the channel-0 value, and it wins when both match on the same tick.
- R11: Among the enabled pending sources, the vector register (address 6) reads 2 for channel 1 and 10 for overflow, and 0 when neither is pending. Channel 1 has priority. A read strobe clears the flag of the source it reported.
- R12: A compare match sets the channel flag. `irq_ch0` equals channel-0 flag AND enable. `irq_shared` is the OR of channel-1 flag AND enable with overflow flag AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable, fed to the prescaler |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only the vector register has a read side effect) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| cap_a | input | 2 | Capture input A, one bit per channel |
| cap_b | input | 2 | Capture input B, one bit per channel |
| cmp_out | output | 2 | Waveform outputs, one bit per channel |
| irq_ch0 | output | 1 | Channel-0 interrupt |
| irq_shared | output | 1 | Channel-1 / overflow interrupt |

## Verification
The hardest states to reach are the edge-aligned ones: a capture while the previous flag is still set, the exact tick where the descending count touches zero, and a waveform output at the tick where both channel compares fire. The stimulus reaches them with the counter held stopped and preloaded through the register port, so every capture value is known exactly. It then starts each run with a write that combines clear and mode, which fixes tick zero and lets every later sample land on a counted edge. The vector priority is set up by writing both flags directly and then issuing read strobes back to back.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int NCH = 2;
  localparam int AW  = 3;

  typedef enum logic [1:0] {
    CM_STOP = 2'd0,
    CM_UP   = 2'd1,
    CM_CONT = 2'd2,
    CM_UPDN = 2'd3
  } cnt_mode_e;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_CNT  = 3'd1;
  localparam logic [AW-1:0] A_CH0C = 3'd2;
  localparam logic [AW-1:0] A_CH0V = 3'd4;
  localparam logic [AW-1:0] A_VEC  = 3'd6;

  localparam int C_OVF   = 0;
  localparam int C_OVFIE = 1;
  localparam int C_CLR   = 2;
  localparam int C_MODE  = 4;
  localparam int C_DIV   = 6;

  localparam int K_FLAG = 0;
  localparam int K_COV  = 1;
  localparam int K_OUT  = 2;
  localparam int K_IE   = 3;
  localparam int K_CAP  = 4;
  localparam int K_OM   = 5;
  localparam int K_EDGE = 8;
  localparam int K_SEL  = 10;
  localparam int K_SYNC = 12;
  localparam int K_BITS = 13;

  localparam int VEC_NONE = 0;
  localparam int VEC_CH1  = 2;
  localparam int VEC_OVF  = 10;
endpackage

// File: rtl/cc_timer_count.sv
module cc_timer_count
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  cnt_mode_e     mode,
  input  logic [1:0]    div,
  input  logic          clr,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          tick,
  output logic          ovf_evt
);
  localparam logic [CW-1:0] ALL1 = '1;

  logic [2:0] pre_q;
  logic [2:0] mask;
  logic       dn_q, dn_nxt, wrap;
  logic       run;

  always_comb begin
    case (div)
      2'd0:    mask = 3'd0;
      2'd1:    mask = 3'd1;
      2'd2:    mask = 3'd3;
      default: mask = 3'd7;
    endcase
  end

  assign run  = (mode != CM_STOP);
  assign tick = ce && run && ((pre_q & mask) == mask) && !clr && !wr;

  always_comb begin
    cnt_nxt = cnt_q;
    dn_nxt  = dn_q;
    wrap    = 1'b0;
    case (mode)
      CM_UP: begin
        if (cnt_q >= top) begin
          cnt_nxt = '0;
          wrap    = 1'b1;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      CM_CONT: begin
        cnt_nxt = cnt_q + 1'b1;
        wrap    = (cnt_q == ALL1);
      end
      CM_UPDN: begin
        if (!dn_q) begin
          if (cnt_q >= top) begin
            if (top == '0) begin
              cnt_nxt = '0;
            end else begin
              cnt_nxt = cnt_q - 1'b1;
              dn_nxt  = 1'b1;
            end
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q <= {{(CW-1){1'b0}}, 1'b1}) begin
            cnt_nxt = '0;
            dn_nxt  = 1'b0;
            wrap    = (cnt_q != '0);
          end else begin
            cnt_nxt = cnt_q - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign ovf_evt = tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      dn_q  <= 1'b0;
    end else if (clr) begin
      cnt_q <= '0;
      pre_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      if (ce && run) pre_q <= pre_q + 1'b1;
      if (wr) begin
        cnt_q <= wdata;
      end else if (tick) begin
        cnt_q <= cnt_nxt;
        dn_q  <= dn_nxt;
      end
    end
  end
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctl,
  input  logic          wr_val,
  input  logic [CW-1:0] wdata,
  input  logic          tick,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          ch0_hit,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          clr_flag,
  output logic [CW-1:0] ctl_rd,
  output logic [CW-1:0] val_q,
  output logic          out_q,
  output logic          flag_q,
  output logic          ie_q,
  output logic          cov_q,
  output logic          set_evt,
  output logic          cap_evt
);
  logic       outbit_q, capm_q, sync_q;
  logic [2:0] om_q;
  logic [1:0] edg_q, sel_q;
  logic       s1_q, s2_q, prev_q;
  logic       raw, sig, rise, fall, own_hit;
  logic       out_nxt;
  logic [2:0] w_om;

  always_comb begin
    case (sel_q)
      2'd0:    raw = in_a;
      2'd1:    raw = in_b;
      2'd2:    raw = 1'b0;
      default: raw = 1'b1;
    endcase
  end

  assign sig     = sync_q ? s2_q : raw;
  assign rise    = sig && !prev_q;
  assign fall    = !sig && prev_q;
  assign cap_evt = capm_q && ((edg_q[0] && rise) || (edg_q[1] && fall));
  assign own_hit = !capm_q && tick && (cnt_nxt == val_q);
  assign set_evt = cap_evt || own_hit;
  assign w_om    = wdata[K_OM+2:K_OM];

  always_comb begin
    out_nxt = out_q;
    case (om_q)
      3'd0: out_nxt = outbit_q;
      3'd1: if (own_hit) out_nxt = 1'b1;
      3'd2: if (ch0_hit) out_nxt = 1'b0; else if (own_hit) out_nxt = !out_q;
      3'd3: if (ch0_hit) out_nxt = 1'b0; else if (own_hit) out_nxt = 1'b1;
      3'd4: if (own_hit) out_nxt = !out_q;
      3'd5: if (own_hit) out_nxt = 1'b0;
      3'd6: if (ch0_hit) out_nxt = 1'b1; else if (own_hit) out_nxt = !out_q;
      default: if (ch0_hit) out_nxt = 1'b1; else if (own_hit) out_nxt = 1'b0;
    endcase
    if (wr_ctl && (w_om == 3'd0)) out_nxt = wdata[K_OUT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= raw;
      s2_q   <= s1_q;
      prev_q <= sig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outbit_q <= 1'b0;
      ie_q     <= 1'b0;
      capm_q   <= 1'b0;
      om_q     <= 3'd0;
      edg_q    <= 2'd0;
      sel_q    <= 2'd0;
      sync_q   <= 1'b0;
    end else if (wr_ctl) begin
      outbit_q <= wdata[K_OUT];
      ie_q     <= wdata[K_IE];
      capm_q   <= wdata[K_CAP];
      om_q     <= w_om;
      edg_q    <= wdata[K_EDGE+1:K_EDGE];
      sel_q    <= wdata[K_SEL+1:K_SEL];
      sync_q   <= wdata[K_SYNC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cov_q  <= 1'b0;
      val_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      out_q <= out_nxt;
      if (set_evt)       flag_q <= 1'b1;
      else if (wr_ctl)   flag_q <= wdata[K_FLAG];
      else if (clr_flag) flag_q <= 1'b0;
      if (cap_evt && flag_q) cov_q <= 1'b1;
      else if (wr_ctl)       cov_q <= wdata[K_COV];
      if (cap_evt)     val_q <= cnt_q;
      else if (wr_val) val_q <= wdata;
    end
  end

  assign ctl_rd = {{(CW-K_BITS){1'b0}}, sync_q, sel_q, edg_q, om_q, capm_q,
                   ie_q, outbit_q, cov_q, flag_q};
endmodule

// File: rtl/cc_timer_vec.sv
module cc_timer_vec
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          rd_vec,
  input  logic          pend_ch1,
  input  logic          pend_ovf,
  output logic [CW-1:0] code,
  output logic          clr_ch1,
  output logic          clr_ovf
);
  always_comb begin
    code    = CW'(VEC_NONE);
    clr_ch1 = 1'b0;
    clr_ovf = 1'b0;
    if (pend_ch1) begin
      code    = CW'(VEC_CH1);
      clr_ch1 = rd_vec;
    end else if (pend_ovf) begin
      code    = CW'(VEC_OVF);
      clr_ovf = rd_vec;
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic [1:0]    cap_a,
  input  logic [1:0]    cap_b,
  output logic [1:0]    cmp_out,
  output logic          irq_ch0,
  output logic          irq_shared
);
  cnt_mode_e    mode_q;
  logic [1:0]   div_q;
  logic         ovf_q, ovfie_q;
  logic         wr_ctrl, clr;
  logic [CW-1:0] cnt_q, cnt_nxt, vec_code;
  logic         tick, ovf_evt, ch0_hit, clr_ch1, clr_ovf;

  logic [NCH-1:0][CW-1:0] ch_ctl, ch_val;
  logic [NCH-1:0] ch_flag, ch_ie, ch_cov, ch_set, ch_cap, ch_clr;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign clr     = wr_ctrl && bus_wdata[C_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= CM_STOP;
      div_q   <= 2'd0;
      ovfie_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode_q  <= cnt_mode_e'(bus_wdata[C_MODE+1:C_MODE]);
        div_q   <= bus_wdata[C_DIV+1:C_DIV];
        ovfie_q <= bus_wdata[C_OVFIE];
      end
      if (ovf_evt)      ovf_q <= 1'b1;
      else if (wr_ctrl) ovf_q <= bus_wdata[C_OVF];
      else if (clr_ovf) ovf_q <= 1'b0;
    end
  end

  cc_timer_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (cnt_en),
    .mode    (mode_q),
    .div     (div_q),
    .clr     (clr),
    .wr      (bus_wr && (bus_addr == A_CNT)),
    .wdata   (bus_wdata),
    .top     (ch_val[0]),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .tick    (tick),
    .ovf_evt (ovf_evt)
  );

  assign ch0_hit = tick && (cnt_nxt == ch_val[0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_clr[i] = (i == 1) ? clr_ch1 : 1'b0;
    cc_timer_chan #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctl   (bus_wr && (bus_addr == A_CH0C + AW'(i))),
      .wr_val   (bus_wr && (bus_addr == A_CH0V + AW'(i))),
      .wdata    (bus_wdata),
      .tick     (tick),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .ch0_hit  (ch0_hit),
      .in_a     (cap_a[i]),
      .in_b     (cap_b[i]),
      .clr_flag (ch_clr[i]),
      .ctl_rd   (ch_ctl[i]),
      .val_q    (ch_val[i]),
      .out_q    (cmp_out[i]),
      .flag_q   (ch_flag[i]),
      .ie_q     (ch_ie[i]),
      .cov_q    (ch_cov[i]),
      .set_evt  (ch_set[i]),
      .cap_evt  (ch_cap[i])
    );
  end

  cc_timer_vec #(.CW(CW)) u_vec (
    .rd_vec   (bus_rd && (bus_addr == A_VEC)),
    .pend_ch1 (ch_flag[1] && ch_ie[1]),
    .pend_ovf (ovf_q && ovfie_q),
    .code     (vec_code),
    .clr_ch1  (clr_ch1),
    .clr_ovf  (clr_ovf)
  );

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = {{(CW-8){1'b0}}, div_q, mode_q, 2'b00, ovfie_q, ovf_q};
      3'd1: bus_rdata = cnt_q;
      3'd2: bus_rdata = ch_ctl[0];
      3'd3: bus_rdata = ch_ctl[1];
      3'd4: bus_rdata = ch_val[0];
      3'd5: bus_rdata = ch_val[1];
      3'd6: bus_rdata = vec_code;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_ch0    = ch_flag[0] && ch_ie[0];
  assign irq_shared = (ch_flag[1] && ch_ie[1]) || (ovf_q && ovfie_q);
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [CW-1:0] bus_wdata,
  input logic [CW-1:0] cnt_q,
  input logic [1:0]    mode_q,
  input logic          tick,
  input logic [CW-1:0] vec_code,
  input logic [1:0]    ch_flag,
  input logic [1:0]    ch_cov,
  input logic [1:0]    ch_set,
  input logic [1:0]    ch_cap
);
  logic cnt_touch;
  assign cnt_touch = bus_wr && (bus_addr == 3'd0 || bus_addr == 3'd1);

  // R6: clear write zeroes the counter
  a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && bus_wdata[2]) |=> (cnt_q == '0));

  // R2: a stopped counter holds its value
  a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !cnt_touch) |=> $stable(cnt_q));

  // R3: continuous mode wraps to zero
  a_r3_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q == 2'd2 && cnt_q == {CW{1'b1}} && !cnt_touch) |=> (cnt_q == '0));

  // R11: only the three legal vector codes appear
  a_r11_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code == 0 || vec_code == 2 || vec_code == 10));

  // R8: capture on a set flag raises capture overflow
  a_r8_cap_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_cap[1] && ch_flag[1] && !(bus_wr && bus_addr == 3'd3)) |=> ch_cov[1]);

  // R11: reading code 2 acknowledges channel 1
  a_r11_read_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd6 && vec_code == 2 && !ch_set[1] &&
     !(bus_wr && bus_addr == 3'd3)) |=> !ch_flag[1]);
endmodule

bind cc_timer cc_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .cnt_q     (cnt_q),
  .mode_q    (mode_q),
  .tick      (tick),
  .vec_code  (vec_code),
  .ch_flag   (ch_flag),
  .ch_cov    (ch_cov),
  .ch_set    (ch_set),
  .ch_cap    (ch_cap)
);

// File: tb/cc_timer_bench.sv
module cc_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  cap_a = 2'b00;
  logic [1:0]  cap_b = 2'b00;
  logic [1:0]  cmp_out;
  logic        irq_ch0, irq_shared;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_a(cap_a), .cap_b(cap_b), .cmp_out(cmp_out),
    .irq_ch0(irq_ch0), .irq_shared(irq_shared)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    peek(3'd0, v); chk("R1", "ctrl", v, 0);
    peek(3'd1, v); chk("R1", "count", v, 0);
    peek(3'd3, v); chk("R1", "ch1 ctl", v, 0);
    peek(3'd6, v); chk("R1", "vector", v, 0);
    chk("R1", "outputs", int'(cmp_out), 0);
    chk("R1", "irqs", int'({irq_ch0, irq_shared}), 0);
  endtask

  task automatic t_up();
    int v;
    wr(3'd0, 16'h0000); wr(3'd4, 16'd5); wr(3'd2, 16'h0008);
    wr(3'd0, 16'h0014);
    step(4); peek(3'd1, v); chk("R2", "up count 4", v, 4);
    chk("R12", "ch0 irq before match", int'(irq_ch0), 0);
    step(1); peek(3'd1, v); chk("R2", "up count 5", v, 5);
    chk("R12", "ch0 irq at match", int'(irq_ch0), 1);
    peek(3'd0, v); chk("R2", "no ovf yet", v & 1, 0);
    step(1); peek(3'd1, v); chk("R2", "up wrap", v, 0);
    peek(3'd0, v); chk("R2", "ovf on wrap", v & 1, 1);
    wr(3'd2, 16'h0000);
  endtask

  task automatic t_updown();
    int v;
    wr(3'd0, 16'h0000); wr(3'd4, 16'd3);
    wr(3'd0, 16'h0034);
    step(3); peek(3'd1, v); chk("R4", "peak", v, 3);
    step(2); peek(3'd1, v); chk("R4", "descending", v, 1);
    peek(3'd0, v); chk("R4", "no ovf before zero", v & 1, 0);
    step(1); peek(3'd1, v); chk("R4", "reach zero", v, 0);
    peek(3'd0, v); chk("R4", "ovf at zero", v & 1, 1);
    step(1); peek(3'd1, v); chk("R4", "turns upward", v, 1);
  endtask

  task automatic t_cont();
    int v;
    wr(3'd0, 16'h0000); wr(3'd0, 16'h0024); wr(3'd1, 16'hFFFD);
    step(2); peek(3'd1, v); chk("R3", "all ones", v, 16'hFFFF);
    peek(3'd0, v); chk("R3", "no ovf yet", v & 1, 0);
    step(1); peek(3'd1, v); chk("R3", "wrap", v, 0);
    peek(3'd0, v); chk("R3", "ovf", v & 1, 1);
  endtask

  task automatic t_div();
    int v;
    wr(3'd0, 16'h0000); wr(3'd0, 16'h00E4);
    step(7); peek(3'd1, v); chk("R5", "div8 before tick", v, 0);
    step(1); peek(3'd1, v); chk("R5", "div8 first tick", v, 1);
    step(8); peek(3'd1, v); chk("R5", "div8 second tick", v, 2);
    wr(3'd0, 16'h0000); wr(3'd0, 16'h0064);
    step(1); peek(3'd1, v); chk("R5", "div2 before tick", v, 0);
    step(1); peek(3'd1, v); chk("R5", "div2 tick", v, 1);
    step(2); peek(3'd1, v); chk("R5", "div2 second", v, 2);
    wr(3'd0, 16'h0064);
    peek(3'd1, v); chk("R6", "clear zeroes count", v, 0);
    peek(3'd0, v); chk("R6", "clear bit reads 0", v, 16'h0060);
    step(1); peek(3'd1, v); chk("R6", "prescaler restarted", v, 0);
  endtask

  task automatic t_outputs();
    wr(3'd0, 16'h0000); wr(3'd4, 16'd4); wr(3'd5, 16'd2);
    wr(3'd3, 16'h0004);
    chk("R10", "mode0 drives level", int'(cmp_out[1]), 1);
    wr(3'd3, 16'h00E4); wr(3'd0, 16'h0014);
    step(1); chk("R10", "reset/set hold", int'(cmp_out[1]), 1);
    step(1); chk("R10", "reset/set own match", int'(cmp_out[1]), 0);
    step(2); chk("R10", "reset/set ch0 match", int'(cmp_out[1]), 1);
    step(3); chk("R10", "reset/set next period", int'(cmp_out[1]), 0);
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    chk("R10", "mode0 low", int'(cmp_out[1]), 0);
    wr(3'd3, 16'h0080); wr(3'd0, 16'h0014);
    step(2); chk("R10", "toggle first", int'(cmp_out[1]), 1);
    step(5); chk("R10", "toggle second", int'(cmp_out[1]), 0);
    step(5); chk("R10", "toggle third", int'(cmp_out[1]), 1);
    wr(3'd4, 16'd2); wr(3'd0, 16'h0000); wr(3'd3, 16'h0004);
    wr(3'd3, 16'h0064); wr(3'd0, 16'h0014);
    step(2); chk("R10", "set/reset coincident ch0 wins", int'(cmp_out[1]), 0);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_capture();
    int v;
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0110); wr(3'd1, 16'h1234);
    cap_a[1] = 1'b1;
    step(1); peek(3'd5, v); chk("R7", "rising capture value", v, 16'h1234);
    peek(3'd3, v); chk("R7", "flag set, no overflow", v & 3, 1);
    cap_a[1] = 1'b0;
    wr(3'd1, 16'h0055);
    peek(3'd5, v); chk("R7", "falling edge ignored", v, 16'h1234);
    cap_a[1] = 1'b1;
    step(1); peek(3'd5, v); chk("R8", "second capture value", v, 16'h0055);
    peek(3'd3, v); chk("R8", "capture overflow", v & 3, 3);
    cap_a[1] = 1'b0; step(1);
    wr(3'd3, 16'h0610); wr(3'd1, 16'h0077);
    cap_b[1] = 1'b1;
    step(1); peek(3'd3, v); chk("R7", "rise on B ignored", v & 1, 0);
    cap_b[1] = 1'b0;
    step(1); peek(3'd3, v); chk("R7", "fall on B captured", v & 3, 1);
    peek(3'd5, v); chk("R7", "fall value", v, 16'h0077);
    wr(3'd3, 16'h0910); step(1);
    wr(3'd3, 16'h0D10);
    peek(3'd3, v); chk("R7", "select one, not yet", v & 1, 0);
    step(1); peek(3'd3, v); chk("R7", "select one rises", v & 1, 1);
  endtask

  task automatic t_sync();
    int v;
    wr(3'd3, 16'h1110); step(3);
    cap_a[1] = 1'b1;
    step(2); peek(3'd3, v); chk("R9", "synchronised, not yet", v & 1, 0);
    step(1); peek(3'd3, v); chk("R9", "synchronised capture", v & 1, 1);
    cap_a[1] = 1'b0; step(3);
  endtask

  task automatic t_vector();
    int v;
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000); wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0001);
    peek(3'd6, v); chk("R11", "disabled ovf not reported", v, 0);
    chk("R12", "shared irq masked", int'(irq_shared), 0);
    wr(3'd0, 16'h0003); wr(3'd3, 16'h0009); wr(3'd2, 16'h0009);
    chk("R12", "shared irq", int'(irq_shared), 1);
    chk("R12", "ch0 irq", int'(irq_ch0), 1);
    rd(3'd6, v); chk("R11", "ch1 first", v, 2);
    rd(3'd6, v); chk("R11", "ovf second", v, 10);
    rd(3'd6, v); chk("R11", "none left", v, 0);
    chk("R11", "shared irq cleared", int'(irq_shared), 0);
    chk("R12", "ch0 untouched by vector", int'(irq_ch0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_updown();
    t_cont();
    t_div();
    t_outputs();
    t_capture();
    t_sync();
    t_vector();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule